// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds the floating-point registers of a processor core, 32 entries of 64 bits, and records beside each entry the data format it last held. A single mode input selects between a wide arrangement, where each entry is a full 64-bit register, and a narrow arrangement, where each entry is a 32-bit register and 64-bit values occupy an even/odd pair. One read port and one write port each take an index and a format code.

Reads are combinational and return a value shaped for the requested format. A typed read whose format disagrees with the recorded tag returns a quiet NaN of the requested format and poisons the tag; a typed read of an entry never typed before adopts the requested format. Accesses that the narrow arrangement cannot express (a 64-bit format on an odd index, or any paired-single access) raise a reserved-instruction exception in the same cycle. Writes and tag updates take effect on the rising clock edge.

Format codes used on both ports: 0 single, 1 double, 2 word (32-bit integer), 3 long (64-bit integer), 4 paired-single (upper single in bits 63:32, lower in 31:0), 5 raw 32-bit move, 6 raw 64-bit move, 7 behaves as 6. Codes 0 to 4 are typed; codes 2, 0 and 5 are 32-bit formats, the others 64-bit.

Top module: `fpr_tagged_file`

## Requirements
- R1: After reset every entry holds zero with an untyped tag, so a first typed read of any entry returns 0 and no exception.
- R2: With wideMode=1, a 64-bit format write followed by a read in the same format returns all 64 bits; a 32-bit format read returns the low 32 bits with bits 63:32 zero.
- R3: With wideMode=0, a 64-bit format write to an even index n stores bits 63:32 in entry n+1 and bits 31:0 in entry n; a 64-bit read of n returns {entry n+1, entry n}, and raw 32-bit reads of n+1 and n return the high and low word.
- R4: A typed read whose format differs from the entry's typed tag returns the quiet NaN of the requested format (single 0x7FBFFFFF, word 0x7FFFFFFF, both zero-extended; double 0x7FF7FFFFFFFFFFFF; long 0x7FFFFFFFFFFFFFFF; paired-single 0x7FBFFFFF7FBFFFFF), and every later typed read of that entry returns a quiet NaN until it is written.
- R5: A typed read of an untyped entry returns its contents and tags the entry with that format, so a later read in the same format returns the contents and one in another format returns a quiet NaN.
- R6: With wideMode=0, a 64-bit format access to an odd index raises the exception output of its port in the same cycle; the read returns 0, the write changes no data, and the write marks both that entry and its even partner poisoned.
- R7: With wideMode=0, any paired-single access raises the exception of its port; the read returns 0, and the write changes no data and poisons only the addressed entry.
- R8: Raw reads (codes 5 to 7) return the stored bits whatever the tag and leave the tag unchanged; raw writes leave the entry untyped.
- R9: rdData is 0 while rdEn is low; a read and a write to the same entry in one cycle return the old contents, and the written format wins the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | 1: 64-bit entries, 0: 32-bit entries with pairing |
| rdEn | input | 1 | Read request |
| rdIdx | input | 5 | Read index |
| rdFmt | input | 3 | Read format code |
| rdData | output | 64 | Read value, combinational |
| rdExc | output | 1 | Reserved-instruction exception for the read |
| wrEn | input | 1 | Write request |
| wrIdx | input | 5 | Write index |
| wrFmt | input | 3 | Write format code |
| wrData | input | 64 | Write value |
| wrExc | output | 1 | Reserved-instruction exception for the write |

## Verification
The assertions take for granted that wideMode only changes between accesses and is not used to reinterpret a pair half-way through, and that the tag-adoption property is only checked in cycles with no write, since a write to the same entry legitimately overrides the read's tag update. The stimulus changes wideMode only between complete operations, never reads an entry left by a 32-bit write in wide mode through a raw 64-bit read, and exercises read/write collisions only in one directed step whose expected result follows the write-wins rule.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int DW = 64;
  localparam int HW = DW / 2;

  typedef enum logic [2:0] {
    FMT_SINGLE = 3'd0, FMT_DOUBLE = 3'd1, FMT_WORD = 3'd2, FMT_LONG = 3'd3,
    FMT_PAIRED = 3'd4, FMT_RAW32 = 3'd5, FMT_RAW64 = 3'd6, FMT_RAW64B = 3'd7
  } fmt_e;

  typedef enum logic [2:0] {
    TAG_SINGLE = 3'd0, TAG_DOUBLE = 3'd1, TAG_WORD = 3'd2, TAG_LONG = 3'd3,
    TAG_PAIRED = 3'd4, TAG_UNINIT = 3'd5, TAG_UNKNOWN = 3'd7
  } tag_e;

  typedef enum logic [2:0] {
    RK_ZERO, RK_LOW, RK_FULL, RK_PAIR, RK_QNAN
  } rdKind_e;

  typedef enum logic [1:0] {
    WS_FILL, WS_ZEXT, WS_FULL
  } wrSel_e;

  typedef struct packed {
    logic    weA;
    wrSel_e  selA;
    logic    weB;
    rdKind_e rdKind;
  } ctrlStrobe_t;

  function automatic logic fmtIs64(input logic [2:0] f);
    return !(f == FMT_SINGLE || f == FMT_WORD || f == FMT_RAW32);
  endfunction

  function automatic logic fmtTyped(input logic [2:0] f);
    return f <= FMT_PAIRED;
  endfunction

  function automatic logic [DW-1:0] qnanFor(input logic [2:0] f);
    logic [HW-1:0] sq;
    sq = 32'h7FBF_FFFF;
    case (f)
      FMT_SINGLE: return {{HW{1'b0}}, sq};
      FMT_WORD:   return {{HW{1'b0}}, 32'h7FFF_FFFF};
      FMT_DOUBLE: return 64'h7FF7_FFFF_FFFF_FFFF;
      FMT_LONG:   return 64'h7FFF_FFFF_FFFF_FFFF;
      FMT_PAIRED: return {sq, sq};
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/fprf_ctrl.sv
module fprf_ctrl
  import fprf_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wideMode,
  input  logic            rdEn,
  input  logic [IDXW-1:0] rdIdx,
  input  logic [2:0]      rdFmt,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [2:0]      wrFmt,
  output ctrlStrobe_t     strobe,
  output logic            rdExc,
  output logic            wrExc
);
  localparam logic [IDXW-1:0] ONE_IDX = 1;

  tag_e tags [NREG];
  tag_e curTag, effTag, newTag;
  logic rdWide, rdTyped, rdAdopt;
  logic wrWide, wrOddPair;
  logic [IDXW-1:0] wrPartner;

  assign curTag  = tags[rdIdx];
  assign rdWide  = fmtIs64(rdFmt);
  assign rdTyped = fmtTyped(rdFmt);
  assign rdExc   = rdEn && !wideMode && (rdFmt == FMT_PAIRED || (rdWide && rdIdx[0]));
  assign rdAdopt = rdEn && !rdExc && rdTyped;

  always_comb begin
    if (curTag == TAG_UNINIT)          effTag = tag_e'(rdFmt);
    else if (curTag == tag_e'(rdFmt))  effTag = curTag;
    else                               effTag = TAG_UNKNOWN;
  end

  assign wrWide    = fmtIs64(wrFmt);
  assign wrExc     = wrEn && !wideMode && (wrFmt == FMT_PAIRED || (wrWide && wrIdx[0]));
  assign wrOddPair = !wideMode && wrWide && wrIdx[0] && wrFmt != FMT_PAIRED;
  assign wrPartner = wrIdx ^ ONE_IDX;
  assign newTag    = fmtTyped(wrFmt) ? tag_e'(wrFmt) : TAG_UNINIT;

  always_comb begin
    strobe.weA  = wrEn && !wrExc;
    strobe.weB  = wrEn && !wrExc && !wideMode && wrWide;
    if (wrWide) strobe.selA = wideMode ? WS_FULL : WS_ZEXT;
    else        strobe.selA = wideMode ? WS_FILL : WS_ZEXT;
    if (!rdEn || rdExc)                         strobe.rdKind = RK_ZERO;
    else if (rdTyped && effTag == TAG_UNKNOWN)  strobe.rdKind = RK_QNAN;
    else if (!rdWide)                           strobe.rdKind = RK_LOW;
    else if (wideMode)                          strobe.rdKind = RK_FULL;
    else                                        strobe.rdKind = RK_PAIR;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rst_n)
        tags[i] <= TAG_UNINIT;
      else if (wrExc && (IDXW'(i) == wrIdx || (wrOddPair && IDXW'(i) == wrPartner)))
        tags[i] <= TAG_UNKNOWN;
      else if (strobe.weA && IDXW'(i) == wrIdx)
        tags[i] <= newTag;
      else if (strobe.weB && IDXW'(i) == wrPartner)
        tags[i] <= newTag;
      else if (rdAdopt && IDXW'(i) == rdIdx)
        tags[i] <= effTag;
    end
  end

  // R5: an untyped entry read with a typed format takes that format
  assert_read_adopts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAdopt && !wrEn && curTag == TAG_UNINIT) |=> tags[$past(rdIdx)] == tag_e'($past(rdFmt)));

  // R6: odd-index 64-bit write in narrow mode poisons the entry and its partner
  assert_odd_write_poisons_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrOddPair) |=> (tags[$past(wrIdx)] == TAG_UNKNOWN && tags[$past(wrPartner)] == TAG_UNKNOWN));

  // R4: a poisoned entry stays poisoned while it is not written
  assert_poison_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (curTag == TAG_UNKNOWN && !wrEn) |=> tags[$past(rdIdx)] == TAG_UNKNOWN);

  // R7: wide mode never raises an exception
  assert_wide_no_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wideMode |-> (!rdExc && !wrExc));
endmodule

// File: rtl/fprf_data.sv
module fprf_data
  import fprf_pkg::*;
#(
  parameter int NREG = 32,
  parameter logic [HW-1:0] FILL = 32'hA5A5_0F0F,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrlStrobe_t     strobe,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [DW-1:0]   wrData,
  input  logic [IDXW-1:0] rdIdx,
  input  logic [2:0]      rdFmt,
  output logic [DW-1:0]   rdData
);
  localparam logic [IDXW-1:0] ONE_IDX = 1;

  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] wordA, wordB, rdLo, rdHi;
  logic [IDXW-1:0] wrPartner, rdPartner;

  assign wrPartner = wrIdx | ONE_IDX;
  assign rdPartner = rdIdx | ONE_IDX;

  always_comb begin
    case (strobe.selA)
      WS_FULL: wordA = wrData;
      WS_FILL: wordA = {FILL, wrData[HW-1:0]};
      default: wordA = {{HW{1'b0}}, wrData[HW-1:0]};
    endcase
    wordB = {{HW{1'b0}}, wrData[DW-1:HW]};
  end

  for (genvar i = 0; i < NREG; i++) begin : g_mem
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (strobe.weA && IDXW'(i) == wrIdx)
        mem[i] <= wordA;
      else if (strobe.weB && IDXW'(i) == wrPartner)
        mem[i] <= wordB;
    end
  end

  assign rdLo = mem[rdIdx];
  assign rdHi = mem[rdPartner];

  always_comb begin
    case (strobe.rdKind)
      RK_LOW:  rdData = {{HW{1'b0}}, rdLo[HW-1:0]};
      RK_FULL: rdData = rdLo;
      RK_PAIR: rdData = {rdHi[HW-1:0], rdLo[HW-1:0]};
      RK_QNAN: rdData = qnanFor(rdFmt);
      default: rdData = '0;
    endcase
  end

  // R2: a full-width write lands unchanged in the addressed entry
  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.weA && strobe.selA == WS_FULL) |=> mem[$past(wrIdx)] == $past(wrData));

  // R3: a split write puts the high word in the odd partner
  assert_pair_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.weB |=> mem[$past(wrPartner)][HW-1:0] == $past(wrData[DW-1:HW]));
endmodule

// File: rtl/fpr_tagged_file.sv
module fpr_tagged_file
  import fprf_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wideMode,
  input  logic            rdEn,
  input  logic [IDXW-1:0] rdIdx,
  input  logic [2:0]      rdFmt,
  output logic [DW-1:0]   rdData,
  output logic            rdExc,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [2:0]      wrFmt,
  input  logic [DW-1:0]   wrData,
  output logic            wrExc
);
  ctrlStrobe_t strobe;

  fprf_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdFmt(rdFmt),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrFmt(wrFmt),
    .strobe(strobe), .rdExc(rdExc), .wrExc(wrExc)
  );

  fprf_data #(.NREG(NREG)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdFmt(rdFmt), .rdData(rdData)
  );

  // R6: an excepting read never returns data
  assert_exc_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdExc |-> rdData == '0);

  // R9: an idle read port outputs zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> rdData == '0);
endmodule

// File: tb/fpr_tagged_file_tb.sv
`timescale 1ns/1ps
module fpr_tagged_file_tb;
  typedef struct packed {
    logic        wide;
    logic        wr;
    logic [4:0]  idx;
    logic [2:0]  fmt;
    logic [63:0] data;
    logic [63:0] exp;
    logic        expExc;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] QS = 64'h0000_0000_7FBF_FFFF;
  localparam logic [63:0] QW = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] QD = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [63:0] QL = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] QP = 64'h7FBF_FFFF_7FBF_FFFF;
  localparam logic [63:0] VA = 64'h4009_21FB_5444_2D18;
  localparam logic [63:0] VP = 64'h4000_0000_BF80_0000;
  localparam logic [63:0] VL = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VR = 64'hC0DE_0000_1234_5678;
  localparam int NV = 32;

  // fields: wide, wr, idx, fmt, data, expected read, expected exception, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 5'd2,  3'd1, VA, 64'd0, 1'b0, 4'd2},  // R2 write double
    '{1'b1, 1'b0, 5'd2,  3'd1, 64'd0, VA, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 5'd2,  3'd3, 64'd0, QL, 1'b0, 4'd4},  // R4 long qnan
    '{1'b1, 1'b0, 5'd2,  3'd1, 64'd0, QD, 1'b0, 4'd4},  // R4 sticky
    '{1'b1, 1'b0, 5'd2,  3'd6, 64'd0, VA, 1'b0, 4'd8},  // R8 raw ignores tag
    '{1'b1, 1'b1, 5'd4,  3'd0, 64'h1111_2222_3F80_0000, 64'd0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 5'd4,  3'd0, 64'd0, 64'h0000_0000_3F80_0000, 1'b0, 4'd2}, // R2 low
    '{1'b1, 1'b0, 5'd4,  3'd2, 64'd0, QW, 1'b0, 4'd4},  // R4 word qnan
    '{1'b1, 1'b1, 5'd6,  3'd4, VP, 64'd0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 5'd6,  3'd4, 64'd0, VP, 1'b0, 4'd2},  // R2 paired
    '{1'b1, 1'b0, 5'd6,  3'd0, 64'd0, QS, 1'b0, 4'd4},  // R4 single qnan
    '{1'b1, 1'b0, 5'd6,  3'd4, 64'd0, QP, 1'b0, 4'd4},  // R4 paired qnan
    '{1'b0, 1'b1, 5'd8,  3'd3, VL, 64'd0, 1'b0, 4'd3},  // R3 split write
    '{1'b0, 1'b0, 5'd8,  3'd3, 64'd0, VL, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b0, 5'd9,  3'd5, 64'd0, 64'h0000_0000_0123_4567, 1'b0, 4'd3}, // R3 high
    '{1'b0, 1'b0, 5'd8,  3'd5, 64'd0, 64'h0000_0000_89AB_CDEF, 1'b0, 4'd3}, // R3 low
    '{1'b0, 1'b1, 5'd11, 3'd1, VA, 64'd0, 1'b1, 4'd6},  // R6 odd write
    '{1'b0, 1'b0, 5'd11, 3'd5, 64'd0, 64'd0, 1'b0, 4'd6}, // R6 unchanged
    '{1'b0, 1'b0, 5'd10, 3'd0, 64'd0, QS, 1'b0, 4'd6},  // R6 partner poisoned
    '{1'b0, 1'b0, 5'd11, 3'd2, 64'd0, QW, 1'b0, 4'd6},  // R6 entry poisoned
    '{1'b0, 1'b0, 5'd13, 3'd1, 64'd0, 64'd0, 1'b1, 4'd6}, // R6 odd read
    '{1'b0, 1'b1, 5'd12, 3'd4, VP, 64'd0, 1'b1, 4'd7},  // R7 paired write
    '{1'b0, 1'b0, 5'd12, 3'd6, 64'd0, 64'd0, 1'b0, 4'd7}, // R7 unchanged
    '{1'b0, 1'b0, 5'd12, 3'd0, 64'd0, QS, 1'b0, 4'd7},  // R7 poisoned
    '{1'b0, 1'b0, 5'd14, 3'd4, 64'd0, 64'd0, 1'b1, 4'd7}, // R7 paired read
    '{1'b1, 1'b1, 5'd21, 3'd6, VR, 64'd0, 1'b0, 4'd8},  // R8 raw write
    '{1'b1, 1'b0, 5'd21, 3'd3, 64'd0, VR, 1'b0, 4'd5},  // R5 adopt long
    '{1'b1, 1'b0, 5'd21, 3'd3, 64'd0, VR, 1'b0, 4'd5},  // R5 kept
    '{1'b1, 1'b0, 5'd21, 3'd1, 64'd0, QD, 1'b0, 4'd5},  // R5 other format
    '{1'b1, 1'b1, 5'd2,  3'd5, 64'hFFFF_FFFF_4049_0FDB, 64'd0, 1'b0, 4'd8}, // R8
    '{1'b1, 1'b0, 5'd2,  3'd0, 64'd0, 64'h0000_0000_4049_0FDB, 1'b0, 4'd8}, // R8 untyped again
    '{1'b1, 1'b0, 5'd2,  3'd5, 64'd0, 64'h0000_0000_4049_0FDB, 1'b0, 4'd8}  // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wideMode = 1'b1;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [4:0] rdIdx = '0, wrIdx = '0;
  logic [2:0] rdFmt = '0, wrFmt = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic rdExc, wrExc;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fpr_tagged_file u_dut (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdFmt(rdFmt), .rdData(rdData), .rdExc(rdExc),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrFmt(wrFmt), .wrData(wrData), .wrExc(wrExc)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rdEn = 1'b0;
    wrEn = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    wideMode = v.wide;
    rdEn = !v.wr;
    wrEn = v.wr;
    rdIdx = v.idx;  rdFmt = v.fmt;
    wrIdx = v.idx;  wrFmt = v.fmt;  wrData = v.data;
    #1;
    checks++;
    if (v.wr) begin
      if (wrExc !== v.expExc) begin
        failures++;
        $display("FAIL R%0d: wrExc actual=%b expected=%b", v.req, wrExc, v.expExc);
      end
    end else if (rdExc !== v.expExc || rdData !== v.exp) begin
      failures++;
      $display("FAIL R%0d: read actual=%h/%b expected=%h/%b", v.req, rdData, rdExc, v.exp, v.expExc);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fresh entry reads zero, no exception
    runVec('{1'b1, 1'b0, 5'd3, 3'd1, 64'd0, 64'd0, 1'b0, 4'd1});
    runVec('{1'b0, 1'b0, 5'd30, 3'd3, 64'd0, 64'd0, 1'b0, 4'd1});
    // R9: idle read port outputs zero
    idle();
    #1;
    check64("R9 idle", rdData, 64'd0);

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R9: read and write of one entry in the same cycle
    runVec('{1'b1, 1'b1, 5'd25, 3'd0, 64'h0000_0000_3F80_0000, 64'd0, 1'b0, 4'd9});
    @(negedge clk);
    wideMode = 1'b1;
    rdEn = 1'b1; rdIdx = 5'd25; rdFmt = 3'd0;
    wrEn = 1'b1; wrIdx = 5'd25; wrFmt = 3'd1; wrData = 64'h4000_0000_0000_0000;
    #1;
    check64("R9 old data", rdData, 64'h0000_0000_3F80_0000);
    runVec('{1'b1, 1'b0, 5'd25, 3'd1, 64'd0, 64'h4000_0000_0000_0000, 1'b0, 4'd9});
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule